// File: doc/BRIEF.md
# Counter-Mode Scrambled Memory Word Datapath

This block sits in front of a small single-port word store and keeps its contents scrambled. For every access it forms a 64-bit counter-mode initial value from the current nonce and the word address and presents it on an output port. A block cipher outside this block turns that value into a 64-bit keystream block and returns it on an input port in the same cycle. The keystream is stretched or cut to the data width and XORed with the stored word.

A plain XOR spreads nothing between bits, so every data chunk also passes through a keyless substitution-permutation network. Writes are diffused first and then XORed. Reads are XORed first and then passed through the inverse network. Chunk-wide write enables allow partial writes without a read-modify-write. Requests are refused while the key is not valid. An even parity bit is kept for each plaintext byte and checked after descrambling. A mismatch is reported as an uncorrectable error.

Top module: `scr_mem_front`

## Requirements
- R1: `iv_o` equals `{nonce_i, addr_i}` in the same cycle: the address fills the low `$clog2(Depth)` bits and the nonce fills the remaining upper bits of the 64.
- R2: `gnt_o` equals `req_i` while `key_valid_i` is high and is 0 while `key_valid_i` is low. A request made while the key is invalid writes nothing and produces no `rvalid_o`.
- R3: On a granted write, each DiffWidth-bit chunk is diffused with NumDiffRounds rounds, keyless. Each round substitutes every nibble through the table 0..F -> C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2. It then reverses the bit order of the chunk. Finally it moves the bit at even position 2i to position i and the bit at odd position 2i+1 to position i+DiffWidth/2. The diffused word XOR the fitted keystream is stored.
- R4: Bit i of the fitted keystream is `keystream_i[i mod 64]`. This cuts the block for widths below 64 and repeats it for widths above 64.
- R5: A read granted at a clock edge raises `rvalid_o` for one cycle after that edge. `rdata_o` is then the inverse network applied to (stored word XOR the keystream fitted from `keystream_i` as sampled at the grant). A read with the same nonce as the write returns the written data.
- R6: `wmask_i[j]` enables chunk j, data bits `[j*DiffWidth +: DiffWidth]`, on a write. Chunks with a zero enable keep their stored content and parity.
- R7: The parity of each byte b, bits `[8b +: 8]`, is the XOR of the plaintext write data bits and is stored with the byte. `rerror_o[1]` is high with `rvalid_o` when the XOR of any descrambled byte differs from its stored parity. `rerror_o[0]` is always 0.
- R8: While `rvalid_o` is low, `rdata_o` and `rerror_o` are zero. A synchronous active-low reset clears `rvalid_o`, including a read pending at the reset edge.
- R9: A granted write produces no `rvalid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| key_valid_i | input | 1 | Key and nonce are usable |
| nonce_i | input | 64-$clog2(Depth) | Scrambling nonce |
| req_i | input | 1 | Access request |
| write_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | $clog2(Depth) | Word address |
| wdata_i | input | Width | Plaintext write data |
| wmask_i | input | Width/DiffWidth | Per-chunk write enable |
| keystream_i | input | 64 | Keystream block for the value on iv_o |
| gnt_o | output | 1 | Request accepted |
| iv_o | output | 64 | Counter-mode initial value |
| rdata_o | output | Width | Descrambled read data |
| rvalid_o | output | 1 | Read data valid |
| rerror_o | output | 2 | Bit 1 uncorrectable (parity), bit 0 always 0 |

## Verification
The bench builds the block with Width=96, Depth=8, DiffWidth=8, NumDiffRounds=2 and parity enabled. A 96-bit word uses the keystream block once in full and then a second time cut to 32 bits, so both the repeat and the cut of R4 show at the read port. Reading with a nonce other than the one used for writing gives data that the bench predicts from its own network and keystream model. This also tests the diffusion, the parity flag and the split of a word whose chunks were written under different nonces. The 3-bit address with a 61-bit nonce also tests the packing of the initial value.

// File: rtl/scr_pkg.sv
// Package with the nibble substitution shared by the diffusion network.
// Assumes 4-bit nibbles. The inverse table is derived, not stored.
package scr_pkg;

    // Forward nibble substitution.
    function automatic logic [3:0] sbox_fwd(input logic [3:0] n);
        logic [3:0] r;
        case (n)
            4'h0: r = 4'hC;  4'h1: r = 4'h5;  4'h2: r = 4'h6;  4'h3: r = 4'hB;
            4'h4: r = 4'h9;  4'h5: r = 4'h0;  4'h6: r = 4'hA;  4'h7: r = 4'hD;
            4'h8: r = 4'h3;  4'h9: r = 4'hE;  4'hA: r = 4'hF;  4'hB: r = 4'h8;
            4'hC: r = 4'h4;  4'hD: r = 4'h7;  4'hE: r = 4'h1;  default: r = 4'h2;
        endcase
        return r;
    endfunction

    // Inverse nibble substitution found by searching the forward table.
    function automatic logic [3:0] sbox_inv(input logic [3:0] n);
        logic [3:0] r;
        r = 4'h0;
        for (int v = 0; v < 16; v++) begin
            if (sbox_fwd(4'(v)) == n) r = 4'(v);
        end
        return r;
    endfunction

endpackage

// File: rtl/scr_chunk_sp.sv
// Keyless substitution-permutation network on one chunk.
// It runs forward or inverse, chosen by Inverse. Assumes W is a multiple of 4.
module scr_chunk_sp #(
    parameter int W       = 8,
    parameter int Rounds  = 2,
    parameter bit Inverse = 1'b0
) (
    input  logic [W-1:0] in_i,
    output logic [W-1:0] out_o
);
    import scr_pkg::*;

    localparam int NumNib = W / 4;
    localparam int Half   = W / 2;

    function automatic logic [W-1:0] subst(input logic [W-1:0] x, input bit inv);
        logic [W-1:0] y;
        for (int k = 0; k < NumNib; k++) begin
            y[k*4 +: 4] = inv ? sbox_inv(x[k*4 +: 4]) : sbox_fwd(x[k*4 +: 4]);
        end
        return y;
    endfunction

    function automatic logic [W-1:0] flip(input logic [W-1:0] x);
        logic [W-1:0] y;
        for (int k = 0; k < W; k++) y[k] = x[W-1-k];
        return y;
    endfunction

    function automatic logic [W-1:0] gather(input logic [W-1:0] x);
        logic [W-1:0] y;
        for (int k = 0; k < Half; k++) begin
            y[k]        = x[2*k];
            y[k + Half] = x[2*k + 1];
        end
        return y;
    endfunction

    function automatic logic [W-1:0] scatter(input logic [W-1:0] x);
        logic [W-1:0] y;
        for (int k = 0; k < Half; k++) begin
            y[2*k]     = x[k];
            y[2*k + 1] = x[k + Half];
        end
        return y;
    endfunction

    function automatic logic [W-1:0] fwd_f(input logic [W-1:0] x);
        logic [W-1:0] s;
        s = x;
        for (int r = 0; r < Rounds; r++) s = gather(flip(subst(s, 1'b0)));
        return s;
    endfunction

    function automatic logic [W-1:0] inv_f(input logic [W-1:0] x);
        logic [W-1:0] s;
        s = x;
        for (int r = 0; r < Rounds; r++) s = subst(flip(scatter(s)), 1'b1);
        return s;
    endfunction

    // Apply the selected direction of the network.
    always_comb begin
        out_o = Inverse ? inv_f(in_i) : fwd_f(in_i);
    end

    // Confirm the opposite direction restores the chunk.
    always_comb begin
        // R3
        roundtrip_chk: assert (Inverse ? (fwd_f(out_o) == in_i) : (inv_f(out_o) == in_i));
    end

endmodule

// File: rtl/scr_diffuse.sv
// Applies the chunk network across a full word, one instance per chunk.
// Assumes Width is a multiple of DiffWidth. Rounds = 0 passes data through.
module scr_diffuse #(
    parameter int Width     = 32,
    parameter int DiffWidth = 8,
    parameter int Rounds    = 2,
    parameter bit Inverse   = 1'b0
) (
    input  logic [Width-1:0] data_i,
    output logic [Width-1:0] data_o
);
    localparam int NumChunks = Width / DiffWidth;

    if (Rounds == 0) begin : g_bypass
        assign data_o = data_i;
    end else begin : g_net
        for (genvar j = 0; j < NumChunks; j++) begin : g_chunk
            scr_chunk_sp #(
                .W      (DiffWidth),
                .Rounds (Rounds),
                .Inverse(Inverse)
            ) u_chunk (
                .in_i (data_i[j*DiffWidth +: DiffWidth]),
                .out_o(data_o[j*DiffWidth +: DiffWidth])
            );
        end
    end

endmodule

// File: rtl/scr_ks_fit.sv
// Fits a 64-bit keystream block to the data width. Bit i takes block bit i mod 64.
// This cuts the block for narrow words and repeats it for wide words.
module scr_ks_fit #(
    parameter int Width = 32
) (
    input  logic [63:0]      ks_i,
    output logic [Width-1:0] ks_o
);
    for (genvar i = 0; i < Width; i++) begin : g_bit
        assign ks_o[i] = ks_i[i % 64];
    end
endmodule

// File: rtl/scr_store.sv
// Word store for ciphertext plus per-byte parity.
// Byte writes are enabled through their chunk. Read data is registered, so it is
// ready one cycle after re_i. The contents are not reset.
module scr_store #(
    parameter int Width        = 32,
    parameter int Depth        = 16,
    parameter int DiffWidth    = 8,
    parameter bit EnableParity = 1'b1
) (
    input  logic                       clk_i,
    input  logic                       we_i,
    input  logic                       re_i,
    input  logic [$clog2(Depth)-1:0]   addr_i,
    input  logic [Width-1:0]           wdata_i,
    input  logic [Width/8-1:0]         wpar_i,
    input  logic [Width/DiffWidth-1:0] wen_i,
    output logic [Width-1:0]           rdata_o,
    output logic [Width/8-1:0]         rpar_o
);
    localparam int NumBytes = Width / 8;

    logic [Width-1:0] mem [Depth];
    logic [Width-1:0] rdata_q;

    // Write the enabled bytes of the ciphertext word.
    always_ff @(posedge clk_i) begin
        if (we_i) begin
            for (int b = 0; b < NumBytes; b++) begin
                if (wen_i[(b*8)/DiffWidth]) mem[addr_i][b*8 +: 8] <= wdata_i[b*8 +: 8];
            end
        end
    end

    // Capture the addressed ciphertext word on a read.
    always_ff @(posedge clk_i) begin
        if (re_i) rdata_q <= mem[addr_i];
    end

    assign rdata_o = rdata_q;

    if (EnableParity) begin : g_par
        logic [NumBytes-1:0] pmem [Depth];
        logic [NumBytes-1:0] rpar_q;

        // Write the parity bits of the enabled bytes.
        always_ff @(posedge clk_i) begin
            if (we_i) begin
                for (int b = 0; b < NumBytes; b++) begin
                    if (wen_i[(b*8)/DiffWidth]) pmem[addr_i][b] <= wpar_i[b];
                end
            end
        end

        // Capture the parity bits together with the data word.
        always_ff @(posedge clk_i) begin
            if (re_i) rpar_q <= pmem[addr_i];
        end

        assign rpar_o = rpar_q;
    end else begin : g_nopar
        assign rpar_o = '0;
    end

endmodule

// File: rtl/scr_mem_front.sv
// Counter-mode scrambling front end for a single-port word store.
// It presents {nonce, address} as the counter value and expects the matching keystream
// block in the same cycle. Writes are diffused and then XORed; reads are XORed and then
// diffused inversely. Read results appear one cycle after the grant.
module scr_mem_front #(
    parameter int Width         = 32,
    parameter int Depth         = 16,
    parameter int DiffWidth     = 8,
    parameter int NumDiffRounds = 2,
    parameter bit EnableParity  = 1'b1
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         key_valid_i,
    input  logic [64-$clog2(Depth)-1:0]  nonce_i,
    input  logic                         req_i,
    input  logic                         write_i,
    input  logic [$clog2(Depth)-1:0]     addr_i,
    input  logic [Width-1:0]             wdata_i,
    input  logic [Width/DiffWidth-1:0]   wmask_i,
    input  logic [63:0]                  keystream_i,
    output logic                         gnt_o,
    output logic [63:0]                  iv_o,
    output logic [Width-1:0]             rdata_o,
    output logic                         rvalid_o,
    output logic [1:0]                   rerror_o
);
    localparam int NumBytes = Width / 8;

    logic                gnt, wr_go, rd_go;
    logic [Width-1:0]    diff_w, ks_w, ct_w;
    logic [NumBytes-1:0] par_w;
    logic [63:0]         ks_q;
    logic                rvalid_q;
    logic [Width-1:0]    ct_r, ks_r, plain_r;
    logic [NumBytes-1:0] par_r, par_calc;
    logic                par_bad;

    assign gnt   = req_i & key_valid_i;
    assign wr_go = gnt & write_i;
    assign rd_go = gnt & ~write_i;
    assign gnt_o = gnt;
    assign iv_o  = {nonce_i, addr_i};

    scr_diffuse #(.Width(Width), .DiffWidth(DiffWidth), .Rounds(NumDiffRounds), .Inverse(1'b0))
        u_diff_w (.data_i(wdata_i), .data_o(diff_w));

    scr_ks_fit #(.Width(Width)) u_fit_w (.ks_i(keystream_i), .ks_o(ks_w));

    assign ct_w = diff_w ^ ks_w;

    // Even parity of each plaintext write byte.
    always_comb begin
        for (int b = 0; b < NumBytes; b++) par_w[b] = ^wdata_i[b*8 +: 8];
    end

    scr_store #(.Width(Width), .Depth(Depth), .DiffWidth(DiffWidth), .EnableParity(EnableParity))
        u_store (
            .clk_i  (clk_i),
            .we_i   (wr_go),
            .re_i   (rd_go),
            .addr_i (addr_i),
            .wdata_i(ct_w),
            .wpar_i (par_w),
            .wen_i  (wmask_i),
            .rdata_o(ct_r),
            .rpar_o (par_r)
        );

    // Track the read response and hold the keystream sampled at the read grant.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rvalid_q <= 1'b0;
            ks_q     <= '0;
        end else begin
            rvalid_q <= rd_go;
            if (rd_go) ks_q <= keystream_i;
        end
    end

    scr_ks_fit #(.Width(Width)) u_fit_r (.ks_i(ks_q), .ks_o(ks_r));

    scr_diffuse #(.Width(Width), .DiffWidth(DiffWidth), .Rounds(NumDiffRounds), .Inverse(1'b1))
        u_diff_r (.data_i(ct_r ^ ks_r), .data_o(plain_r));

    // Recompute parity on the descrambled word and compare it with the stored bits.
    always_comb begin
        for (int b = 0; b < NumBytes; b++) par_calc[b] = ^plain_r[b*8 +: 8];
        par_bad = EnableParity && (par_calc != par_r);
    end

    assign rvalid_o = rvalid_q;
    assign rdata_o  = rvalid_q ? plain_r : '0;
    assign rerror_o = {rvalid_q & par_bad, 1'b0};

    // R5
    rvalid_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rvalid_o |-> $past(req_i && key_valid_i && !write_i));

    // R2
    blocked_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && !key_valid_i) |=> !rvalid_o);

    // R7
    err_with_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rerror_o[1] |-> rvalid_o);

    // R8
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rvalid_o |-> (rdata_o == '0 && rerror_o == 2'b00));

endmodule

// File: tb/sim_scr_mem_front.sv
module sim_scr_mem_front;
    localparam int W  = 96;
    localparam int D  = 8;
    localparam int NC = 12;
    localparam int NB = 12;

    typedef struct packed {
        logic        wr;
        logic [2:0]  addr;
        logic        nsel;
        logic [95:0] data;
        logic [11:0] mask;
    } vec_t;

    localparam logic [60:0] NONCE0 = 61'h0ABC_DEF0_1234_5678;
    localparam logic [60:0] NONCE1 = 61'h1357_9BDF_2468_ACE0;

    localparam vec_t VECS [14] = '{
        '{1'b1, 3'd1, 1'b0, 96'h0123_4567_89AB_CDEF_FEDC_BA98, 12'hFFF},
        '{1'b0, 3'd1, 1'b0, 96'h0, 12'h0},
        '{1'b1, 3'd5, 1'b0, 96'hDEAD_BEEF_CAFE_F00D_1234_5678, 12'hFFF},
        '{1'b1, 3'd5, 1'b1, 96'h5555_AAAA_0F0F_F0F0_3C3C_C3C3, 12'h0A5},
        '{1'b0, 3'd5, 1'b0, 96'h0, 12'h0},
        '{1'b0, 3'd5, 1'b1, 96'h0, 12'h0},
        '{1'b0, 3'd1, 1'b1, 96'h0, 12'h0},
        '{1'b1, 3'd7, 1'b1, 96'h0, 12'hFFF},
        '{1'b0, 3'd7, 1'b1, 96'h0, 12'h0},
        '{1'b1, 3'd0, 1'b0, {96{1'b1}}, 12'hFFF},
        '{1'b0, 3'd0, 1'b0, 96'h0, 12'h0},
        '{1'b1, 3'd7, 1'b0, 96'h8000_0000_0000_0000_0000_0001, 12'h800},
        '{1'b0, 3'd7, 1'b0, 96'h0, 12'h0},
        '{1'b0, 3'd7, 1'b1, 96'h0, 12'h0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          key_valid = 1'b0;
    logic [60:0]   nonce = '0;
    logic          req = 1'b0;
    logic          write = 1'b0;
    logic [2:0]    addr = '0;
    logic [W-1:0]  wdata = '0;
    logic [NC-1:0] wmask = '0;
    logic [63:0]   ks;
    logic          gnt;
    logic [63:0]   iv;
    logic [W-1:0]  rdata;
    logic          rvalid;
    logic [1:0]    rerror;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [W-1:0]  m_ct  [D];
    logic [NB-1:0] m_par [D];

    always #2.5 clk = ~clk;

    function automatic logic [63:0] bks(input logic [63:0] v);
        return (v * 64'h9E37_79B9_7F4A_7C15) ^ {v[15:0], v[63:16]} ^ 64'h0F1E_2D3C_4B5A_6978;
    endfunction

    assign ks = bks(iv);

    scr_mem_front #(.Width(W), .Depth(D), .DiffWidth(8), .NumDiffRounds(2), .EnableParity(1'b1)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .key_valid_i(key_valid), .nonce_i(nonce), .req_i(req),
        .write_i(write), .addr_i(addr), .wdata_i(wdata), .wmask_i(wmask), .keystream_i(ks),
        .gnt_o(gnt), .iv_o(iv), .rdata_o(rdata), .rvalid_o(rvalid), .rerror_o(rerror)
    );

    function automatic logic [3:0] b_sb(input logic [3:0] n);
        logic [3:0] t [16] = '{4'hC, 4'h5, 4'h6, 4'hB, 4'h9, 4'h0, 4'hA, 4'hD,
                               4'h3, 4'hE, 4'hF, 4'h8, 4'h4, 4'h7, 4'h1, 4'h2};
        return t[n];
    endfunction

    function automatic logic [3:0] b_isb(input logic [3:0] n);
        logic [3:0] t [16] = '{4'h5, 4'hE, 4'hF, 4'h8, 4'hC, 4'h1, 4'h2, 4'hD,
                               4'hB, 4'h4, 4'h6, 4'h3, 4'h0, 4'h7, 4'h9, 4'hA};
        return t[n];
    endfunction

    function automatic logic [7:0] b_fwd(input logic [7:0] x);
        logic [7:0] s, y, z;
        s = x;
        for (int r = 0; r < 2; r++) begin
            s = {b_sb(s[7:4]), b_sb(s[3:0])};
            for (int i = 0; i < 8; i++) y[i] = s[7-i];
            for (int i = 0; i < 4; i++) begin z[i] = y[2*i]; z[i+4] = y[2*i+1]; end
            s = z;
        end
        return s;
    endfunction

    function automatic logic [7:0] b_inv(input logic [7:0] x);
        logic [7:0] s, y, z;
        s = x;
        for (int r = 0; r < 2; r++) begin
            for (int i = 0; i < 4; i++) begin y[2*i] = s[i]; y[2*i+1] = s[i+4]; end
            for (int i = 0; i < 8; i++) z[i] = y[7-i];
            s = {b_isb(z[7:4]), b_isb(z[3:0])};
        end
        return s;
    endfunction

    function automatic logic [W-1:0] b_fit(input logic [63:0] k);
        logic [W-1:0] f;
        for (int i = 0; i < W; i++) f[i] = k[i % 64];
        return f;
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // One access: drive at a falling edge, check grant and iv, then check the response.
    task automatic op(input bit wr, input logic [2:0] a, input bit ns, input logic [W-1:0] d,
                      input logic [NC-1:0] m, input bit kv);
        logic [60:0]  nv;
        logic [W-1:0] f, c, exp_d;
        bit           exp_e;
        nv = ns ? NONCE1 : NONCE0;
        key_valid = kv; nonce = nv; write = wr; addr = a; wdata = d; wmask = m; req = 1'b1;
        #1;
        chk(iv == {nv, a}, "R1 iv", W'(iv), W'({nv, a}));
        chk(gnt == kv, "R2 gnt", W'(gnt), W'(kv));
        f = b_fit(bks({nv, a}));
        exp_d = '0; exp_e = 1'b0;
        if (kv && wr) begin
            for (int j = 0; j < NC; j++) begin
                if (m[j]) begin
                    m_ct[a][j*8 +: 8] = b_fwd(d[j*8 +: 8]) ^ f[j*8 +: 8];
                    m_par[a][j] = ^d[j*8 +: 8];
                end
            end
        end else if (kv) begin
            c = m_ct[a] ^ f;
            for (int j = 0; j < NC; j++) begin
                exp_d[j*8 +: 8] = b_inv(c[j*8 +: 8]);
                if ((^exp_d[j*8 +: 8]) != m_par[a][j]) exp_e = 1'b1;
            end
        end
        @(posedge clk);
        @(negedge clk);
        req = 1'b0;
        #1;
        if (kv && !wr) begin
            chk(rvalid == 1'b1, "R5 rvalid", W'(rvalid), W'(1));
            chk(rdata == exp_d, "R5 R4 R3 R6 rdata", rdata, exp_d);
            chk(rerror[1] == exp_e, "R7 rerror[1]", W'(rerror[1]), W'(exp_e));
            chk(rerror[0] == 1'b0, "R7 rerror[0]", W'(rerror[0]), W'(0));
        end else begin
            chk(rvalid == 1'b0, wr ? "R9 no rvalid" : "R2 no rvalid", W'(rvalid), W'(0));
            chk(rdata == '0 && rerror == 2'b00, "R8 idle outputs", rdata, '0);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // Reset state, with a read pending at the reset edge (R8).
        repeat (3) @(negedge clk);
        key_valid = 1'b1; req = 1'b1; write = 1'b0;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0;
        #1;
        chk(rvalid == 1'b0, "R8 reset rvalid", W'(rvalid), W'(0));
        chk(rdata == '0, "R8 reset rdata", rdata, '0);
        chk(rerror == 2'b00, "R8 reset rerror", W'(rerror), W'(0));
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk.
        foreach (VECS[i]) begin
            op(VECS[i].wr, VECS[i].addr, VECS[i].nsel, VECS[i].data, VECS[i].mask, 1'b1);
        end

        // Key invalid: a write is ignored and a read is refused (R2).
        op(1'b1, 3'd1, 1'b0, 96'hFFFF_0000_FFFF_0000_FFFF_0000, 12'hFFF, 1'b0);
        op(1'b0, 3'd1, 1'b0, '0, '0, 1'b0);
        // Read back over the normal path: the old word must remain (R2).
        op(1'b0, 3'd1, 1'b0, '0, '0, 1'b1);
        chk(m_ct[1] != '0, "R2 model sanity", m_ct[1], '0);

        // Masked write with no chunk enabled leaves the word unchanged (R6).
        op(1'b1, 3'd0, 1'b0, 96'h1234_5678_9ABC_DEF0_1357_9BDF, 12'h000, 1'b1);
        op(1'b0, 3'd0, 1'b0, '0, '0, 1'b1);

        // Back-to-back reads (R5).
        op(1'b0, 3'd5, 1'b0, '0, '0, 1'b1);
        op(1'b0, 3'd1, 1'b0, '0, '0, 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule